// File: doc/BRIEF.md
# Phase-Cut Gate Pulse Timer

This block drives the gate-enable bit of a pair of back-to-back power switches once per AC half cycle. A single-cycle zero-cross strobe opens each half cycle. At that strobe the block captures an 8-bit dim code and a force-full flag, converts the code into a pulse width on a piecewise step scale, and counts timebase ticks until the edge of the pulse is reached.

After reset the block waits for a settle period and then latches a mode input, which it keeps until the next reset. With the mode low, the gate opens at the crossing and closes after the on-time. This is trailing-edge dimming. With the mode high, the gate stays closed from the crossing and opens after an off-time, which is the frame length minus the on-time. This is leading-edge dimming. One step is `TICKS_PER_STEP` ticks. The default of 5 ticks at 200 kHz gives 25 µs per step. A value of 6 gives the 50 Hz scaling of +20%.

Top module: `phase_cut_gate_timer`

## Requirements
- R1: After reset release the block counts `SETTLE_TICKS` ticks and then latches `mode_sel` (0 = trailing edge, 1 = leading edge). Later changes of `mode_sel` have no effect until the next reset. `gate_en` stays 0 during reset, before the latch, and after the latch until the first strobe.
- R2: Trailing edge: `gate_en` is 1 from the cycle after the strobe for exactly on-time ticks, then 0 until the next strobe.
- R3: Leading edge: `gate_en` is 0 after the strobe for off-time ticks, with off-time = (332 steps − on-steps) × `TICKS_PER_STEP`. It is 1 from then until the next strobe.
- R4: Codes 0 to 9 give no gate pulse in either mode.
- R5: Codes 10 to 25 give an on-time of 20 + 2·(code − 10) steps (500 µs to 1250 µs).
- R6: Codes 26 to 236 give 50 + (code − 25) steps (1275 µs to 6525 µs). Codes above 236 are clamped to 261 steps.
- R7: When `force_full` is 1 at the strobe, `gate_en` is 1 for the whole half cycle in both modes, whatever the code.
- R8: The code and `force_full` are sampled only at the strobe. Changing them mid half cycle has no effect on the pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| tick | input | 1 | Timebase enable, one pulse per 5 µs |
| zero_cross | input | 1 | Single-cycle zero-cross strobe |
| mode_sel | input | 1 | Dimming mode request, latched after settle |
| force_full | input | 1 | Request 100% duty for the next half cycle |
| dim_code | input | 8 | Dim code from the converter |
| gate_en | output | 1 | Gate-enable to the driver |

## Verification
Each half cycle is checked tick by tick against a model of the expected waveform. Directed codes sit on both sides of the dead zone (9/10), at the knee of the slope (25/26) and at the top of the table and beyond it (236/255). Together they separate an off-by-one in the step scale from a wrong slope or a missing clamp. Both modes are run, each after its own reset, and `mode_sel` is flipped after the latch to show that it is ignored. Random codes are applied with the code and force flag scrambled mid half cycle, which separates sampling at the strobe from following the live inputs. A strobe during the settle window shows that the gate stays closed before the mode is known.

// File: rtl/phase_cut_gate_timer.sv
module phase_cut_gate_timer #(
  parameter int CODE_W         = 8,
  parameter int CNT_W          = 16,
  parameter int TICKS_PER_STEP = 5,
  parameter int SETTLE_TICKS   = 12000,
  parameter int MIN_CODE       = 10,
  parameter int KNEE_CODE      = 25,
  parameter int TOP_CODE       = 236,
  parameter int BASE_STEPS     = 20,
  parameter int FRAME_STEPS    = 332
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              zero_cross,
  input  logic              mode_sel,
  input  logic              force_full,
  input  logic [CODE_W-1:0] dim_code,
  output logic              gate_en
);

  localparam int SW         = $clog2(SETTLE_TICKS + 1);
  localparam int KNEE_STEPS = BASE_STEPS + 2 * (KNEE_CODE - MIN_CODE);
  localparam int TOP_STEPS  = KNEE_STEPS + (TOP_CODE - KNEE_CODE);

  logic [SW-1:0]    settle_cnt;
  logic             locked, mode_le, active, pulse_nz, full_q;
  logic [CNT_W-1:0] hc_cnt, edge_ticks;
  logic [CNT_W-1:0] code_ext, on_steps, sel_steps;
  logic             strobe;

  assign strobe   = zero_cross && locked;
  assign code_ext = CNT_W'(dim_code);

  always_comb begin
    if (code_ext < CNT_W'(MIN_CODE))
      on_steps = '0;
    else if (code_ext <= CNT_W'(KNEE_CODE))
      on_steps = CNT_W'(BASE_STEPS) + ((code_ext - CNT_W'(MIN_CODE)) << 1);
    else if (code_ext <= CNT_W'(TOP_CODE))
      on_steps = CNT_W'(KNEE_STEPS) + (code_ext - CNT_W'(KNEE_CODE));
    else
      on_steps = CNT_W'(TOP_STEPS);
  end

  assign sel_steps = mode_le ? (CNT_W'(FRAME_STEPS) - on_steps) : on_steps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
      locked     <= 1'b0;
      mode_le    <= 1'b0;
    end else if (!locked && tick) begin
      if (settle_cnt == SW'(SETTLE_TICKS - 1)) begin
        locked  <= 1'b1;
        mode_le <= mode_sel;
      end else begin
        settle_cnt <= settle_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      pulse_nz   <= 1'b0;
      full_q     <= 1'b0;
      edge_ticks <= '0;
      hc_cnt     <= '0;
    end else if (strobe) begin
      active     <= 1'b1;
      pulse_nz   <= (on_steps != '0);
      full_q     <= force_full;
      edge_ticks <= CNT_W'(sel_steps * CNT_W'(TICKS_PER_STEP));
      hc_cnt     <= '0;
    end else if (tick && hc_cnt != '1) begin
      hc_cnt <= hc_cnt + 1'b1;
    end
  end

  assign gate_en = active && (full_q ||
                   (mode_le ? (pulse_nz && hc_cnt >= edge_ticks)
                            : (hc_cnt < edge_ticks)));

endmodule

module phase_cut_gate_timer_chk #(
  parameter int CODE_W   = 8,
  parameter int CNT_W    = 16,
  parameter int MIN_CODE = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              zero_cross,
  input logic              force_full,
  input logic [CODE_W-1:0] dim_code,
  input logic              gate_en,
  input logic              locked,
  input logic              mode_le,
  input logic [CNT_W-1:0]  hc_cnt
);

  p_closed_before_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !gate_en);

  p_mode_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> $stable(mode_le));

  p_te_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_cross && locked && !mode_le && dim_code >= CODE_W'(MIN_CODE)) |=> gate_en);

  p_le_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_cross && locked && mode_le && !force_full) |=> !gate_en);

  p_dead_zone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_cross && locked && !force_full && dim_code < CODE_W'(MIN_CODE)) |=> !gate_en);

  p_full_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_cross && locked && force_full) |=> gate_en);

  p_count_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_cross && locked) |=> (hc_cnt == '0));

endmodule

bind phase_cut_gate_timer phase_cut_gate_timer_chk #(
  .CODE_W(CODE_W), .CNT_W(CNT_W), .MIN_CODE(MIN_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .zero_cross(zero_cross), .force_full(force_full),
  .dim_code(dim_code), .gate_en(gate_en), .locked(locked), .mode_le(mode_le),
  .hc_cnt(hc_cnt)
);

// File: tb/phase_cut_gate_timer_tb.sv
module phase_cut_gate_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 5;
  localparam int SETTLE     = 12000;
  localparam int HALF       = 1667;
  localparam int FRAME      = 332;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, zero_cross = 1'b0;
  logic mode_sel = 1'b0, force_full = 1'b0;
  logic [7:0] dim_code = 8'd0;
  logic gate_en;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  int unsigned seed = 32'd7;

  phase_cut_gate_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .zero_cross(zero_cross),
    .mode_sel(mode_sel), .force_full(force_full), .dim_code(dim_code),
    .gate_en(gate_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_steps(int c);
    if (c < 10)       return 0;
    else if (c <= 25) return 20 + 2 * (c - 10);
    else if (c <= 236) return 50 + (c - 25);
    else              return 261;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_half(int code, bit full, bit le, bit scramble, string req);
    int on_t, off_t, bad_k, bad_a, bad_e;
    bit bad, e;
    on_t  = exp_steps(code) * TPS;
    off_t = (FRAME - exp_steps(code)) * TPS;
    bad = 1'b0; bad_k = 0; bad_a = 0; bad_e = 0;
    @(negedge clk);
    zero_cross = 1'b1; dim_code = 8'(code); force_full = full;
    @(negedge clk);
    zero_cross = 1'b0;
    for (int k = 0; k < HALF; k++) begin
      e = full || (le ? (code >= 10 && k >= off_t) : (k < on_t));
      if (gate_en !== e && !bad) begin
        bad = 1'b1; bad_k = k; bad_a = int'(gate_en); bad_e = int'(e);
      end
      if (scramble && k == HALF / 2) begin
        dim_code   = 8'($urandom_range(0, 255));
        force_full = ~full;
      end
      @(negedge clk);
    end
    force_full = 1'b0;
    if (bad)
      $display("  %s code=%0d full=%0d mismatch at tick %0d", req, code, full, bad_k);
    check(!bad, req, bad_a, bad_e);
  endtask

  task automatic do_reset(bit mode);
    bit seen;
    rst_n = 1'b0; mode_sel = mode; zero_cross = 1'b0;
    repeat (5) @(negedge clk);
    check(gate_en == 1'b0, "R1 reset state", int'(gate_en), 0);
    rst_n = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < SETTLE - 10; k++) begin
      if (k == 100) begin zero_cross = 1'b1; dim_code = 8'd200; force_full = 1'b1; end
      if (k == 101) begin zero_cross = 1'b0; force_full = 1'b0; end
      if (gate_en) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R1 gate closed before mode latch", int'(seen), 0);
    repeat (20) @(negedge clk);
    mode_sel = ~mode;
    repeat (5) @(negedge clk);
    check(gate_en == 1'b0, "R1 closed until first strobe", int'(gate_en), 0);
  endtask

  task automatic mode_suite(bit le);
    string tag2, tag3;
    tag2 = le ? "R3 leading edge" : "R2 trailing edge";
    run_half(0,   1'b0, le, 1'b0, "R4 code 0 dead");
    run_half(9,   1'b0, le, 1'b0, "R4 code 9 dead");
    run_half(10,  1'b0, le, 1'b0, "R5 code 10 min width");
    run_half(11,  1'b0, le, 1'b0, "R5 code 11 step");
    run_half(25,  1'b0, le, 1'b0, "R5 code 25 knee");
    run_half(26,  1'b0, le, 1'b0, "R6 code 26 past knee");
    run_half(236, 1'b0, le, 1'b0, "R6 code 236 top");
    run_half(255, 1'b0, le, 1'b0, "R6 code 255 clamp");
    run_half(100, 1'b1, le, 1'b0, "R7 force full");
    run_half(3,   1'b1, le, 1'b0, "R7 force full low code");
    tag3 = le ? "R1 mode held LE" : "R1 mode held TE";
    run_half(120, 1'b0, le, 1'b0, tag3);
    for (int i = 0; i < 8; i++)
      run_half($urandom_range(0, 255), ($urandom_range(0, 7) == 0), le, 1'b1,
               {tag2, " R8 random scrambled"});
  endtask

  initial begin
    void'($urandom(seed));
    do_reset(1'b0);
    mode_suite(1'b0);
    do_reset(1'b1);
    mode_suite(1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule